// File: doc/BRIEF.md
# Chained Interrupt Priority Resolver

This block chooses which interrupt, if any, the processor takes next. Sixteen maskable sources each hold a request bit and a 3-bit level that software sets. They feed a serial chain of compare stages. Position 0 sits at the top of the chain: the external interrupt lines come first and the converter/serial source comes last, at position 15. Each stage passes its own request downstream only when its level is strictly above the best level that reaches it from upstream. So on a tie the upstream stage wins.

The surviving candidate is checked against the processor's current interrupt priority level and its interrupt-disable flag. Three fixed-priority sources sit above every maskable one and ignore that flag. In order they are a reset request, a debug request and a watchdog request.

All inputs are captured once per detection, paced by the opcode-fetch strobe. Values are sampled at the falling clock edge inside the fetch cycle and latched at the next rising edge. They are then held while a blanking window runs, and further fetch strobes are ignored during that window. The result is issued as single-cycle strobes. These tell the surrounding core to set the disable flag, to clear the winning request bit, and which new priority level to load. Stacking the status word and fetching the vector are left to the core.

Top module: `irq_chain_arbiter`

## Requirements
- R1: Among requesting maskable sources, the one with the strictly highest nonzero level wins, and `vec_o` gives its chain position (0 = top of chain).
- R2: When several requesting sources share the highest level, the one with the smallest chain position wins.
- R3: A source whose level is 0 is never accepted, even if its request bit is set and the current priority level is 0.
- R4: A maskable winner is accepted only if its level is strictly greater than the captured `ipl_i` and the captured `iflag_i` is 0. Otherwise there is no accept, no clear and no set-flag strobe.
- R5: On a maskable accept, `kind_o` is 0. `clr_o` has exactly the bit of the winning position set, `set_iflag_o` is 1 and `new_ipl_o` equals the winner's level.
- R6: Fixed sources override all maskable ones, whatever the disable flag or the current level, in the order reset, then debug, then watchdog. `kind_o` reads 1 for reset, 2 for debug and 3 for watchdog. `vec_o` is 0 and `clr_o` is 0. `set_iflag_o` is 1. `new_ipl_o` is 7 for reset and watchdog, and equals the captured `ipl_i` for debug.
- R7: The results appear for exactly one cycle. They register on the second rising edge after the latch edge, and all outputs are 0 in every other cycle.
- R8: A latch happens on a rising edge where `fetch_i` is high and no detection is in progress. Fetch strobes during the two blanking cycles and the result cycle are ignored, so a fetch held high starts a detection every three cycles.
- R9: Inputs are sampled at the falling edge inside the fetch cycle. A change made after that falling edge but before the latch edge does not affect the result.
- R10: Changes to any input during the blanking window do not affect the pending result.
- R11: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_i | input | 1 | Opcode-fetch cycle strobe |
| req_i | input | 16 | Request bit per maskable source, bit n = chain position n |
| lvl_i | input | 48 | Level per source, bits [3n+2:3n] for position n |
| ipl_i | input | 3 | Current processor interrupt priority level |
| iflag_i | input | 1 | Interrupt-disable flag |
| nmi_reset_i | input | 1 | Fixed-priority reset request |
| nmi_debug_i | input | 1 | Fixed-priority debug request |
| nmi_wdog_i | input | 1 | Fixed-priority watchdog request |
| accept_o | output | 1 | An interrupt is accepted this cycle |
| kind_o | output | 2 | 0 maskable, 1 reset, 2 debug, 3 watchdog |
| vec_o | output | 4 | Chain position of the accepted maskable source |
| new_ipl_o | output | 3 | Level the core loads into its priority field |
| clr_o | output | 16 | One-hot request-clear strobe |
| set_iflag_o | output | 1 | Strobe to set the interrupt-disable flag |

## Verification
Each detection is started by raising the fetch strobe just after a rising edge. Its inputs are captured at the next falling edge and latched at the rising edge after that. The results are due at the second rising edge after the latch, and the bench reads them one nanosecond later. It also confirms that `accept_o` is low one cycle before and one cycle after that point. The sampling and blanking tests change inputs at chosen instants: between the falling and the latching edge, and inside the blanking window. They then read the same result slot to show that the snapshot held. With the fetch strobe held high, the bench expects pulses at edges 2, 5 and 8 after the first latch.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
   typedef enum logic [1:0] {
      SRC_MASKABLE = 2'd0,
      SRC_RESET    = 2'd1,
      SRC_DEBUG    = 2'd2,
      SRC_WDOG     = 2'd3
   } src_kind_e;
endpackage

// File: rtl/irq_snapshot.sv
module irq_snapshot #(
   parameter int NUM_SRC           = 16,
   parameter int LVL_W             = 3,
   parameter bit HALF_CYCLE_SAMPLE = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     take_i,
   input  logic                     hold_i,
   input  logic [NUM_SRC-1:0]       req_i,
   input  logic [NUM_SRC*LVL_W-1:0] lvl_i,
   input  logic [LVL_W-1:0]         ipl_i,
   input  logic                     iflag_i,
   input  logic [2:0]               nmi_i,
   output logic [NUM_SRC-1:0]       snap_req_o,
   output logic [NUM_SRC*LVL_W-1:0] snap_lvl_o,
   output logic [LVL_W-1:0]         snap_ipl_o,
   output logic                     snap_iflag_o,
   output logic [2:0]               snap_nmi_o
);
   localparam int SNAP_W = NUM_SRC + NUM_SRC*LVL_W + LVL_W + 1 + 3;

   logic [SNAP_W-1:0] live;
   logic [SNAP_W-1:0] snap_q;

   assign live = {nmi_i, iflag_i, ipl_i, lvl_i, req_i};

   generate
      if (HALF_CYCLE_SAMPLE) begin : g_half
         logic [SNAP_W-1:0] smp_q;
         // first half of the fetch cycle: sample
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n)      smp_q <= '0;
            else if (take_i) smp_q <= live;
         end
         // closing edge of the fetch cycle: latch
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      snap_q <= '0;
            else if (take_i) snap_q <= smp_q;
         end
      end else begin : g_full
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      snap_q <= '0;
            else if (take_i) snap_q <= live;
         end
      end
   endgenerate

   assign {snap_nmi_o, snap_iflag_o, snap_ipl_o, snap_lvl_o, snap_req_o} = snap_q;

   // snapshot frozen while a detection is pending
   assert_snap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> $stable(snap_q));
endmodule

// File: rtl/irq_chain_stage.sv
module irq_chain_stage #(
   parameter int LVL_W = 3,
   parameter int IDX_W = 4,
   parameter int POS   = 0
) (
   input  logic             up_vld_i,
   input  logic [LVL_W-1:0] up_lvl_i,
   input  logic [IDX_W-1:0] up_idx_i,
   input  logic             own_req_i,
   input  logic [LVL_W-1:0] own_lvl_i,
   output logic             dn_vld_o,
   output logic [LVL_W-1:0] dn_lvl_o,
   output logic [IDX_W-1:0] dn_idx_o
);
   logic take_own;

   // strictly higher only: equal levels leave the upstream winner in place
   assign take_own = own_req_i && (own_lvl_i > up_lvl_i);

   always_comb begin
      if (take_own) begin
         dn_vld_o = 1'b1;
         dn_lvl_o = own_lvl_i;
         dn_idx_o = IDX_W'(POS);
      end else begin
         dn_vld_o = up_vld_i;
         dn_lvl_o = up_lvl_i;
         dn_idx_o = up_idx_i;
      end
   end
endmodule

// File: rtl/irq_accept_gate.sv
module irq_accept_gate
   import irq_chain_pkg::*;
#(
   parameter int NUM_SRC = 16,
   parameter int LVL_W   = 3,
   parameter int IDX_W   = 4
) (
   input  logic               win_vld_i,
   input  logic [LVL_W-1:0]   win_lvl_i,
   input  logic [IDX_W-1:0]   win_idx_i,
   input  logic [LVL_W-1:0]   ipl_i,
   input  logic               iflag_i,
   input  logic [2:0]         nmi_i,
   output logic               acc_o,
   output src_kind_e          kind_o,
   output logic [IDX_W-1:0]   vec_o,
   output logic [LVL_W-1:0]   new_ipl_o,
   output logic [NUM_SRC-1:0] clr_o,
   output logic               seti_o
);
   always_comb begin
      acc_o     = 1'b0;
      kind_o    = SRC_MASKABLE;
      vec_o     = '0;
      new_ipl_o = '0;
      clr_o     = '0;
      seti_o    = 1'b0;
      if (nmi_i[2]) begin
         acc_o     = 1'b1;
         kind_o    = SRC_RESET;
         new_ipl_o = '1;
         seti_o    = 1'b1;
      end else if (nmi_i[1]) begin
         acc_o     = 1'b1;
         kind_o    = SRC_DEBUG;
         new_ipl_o = ipl_i;
         seti_o    = 1'b1;
      end else if (nmi_i[0]) begin
         acc_o     = 1'b1;
         kind_o    = SRC_WDOG;
         new_ipl_o = '1;
         seti_o    = 1'b1;
      end else if (win_vld_i && (win_lvl_i > ipl_i) && !iflag_i) begin
         acc_o     = 1'b1;
         vec_o     = win_idx_i;
         new_ipl_o = win_lvl_i;
         clr_o     = NUM_SRC'(1) << win_idx_i;
         seti_o    = 1'b1;
      end
   end
endmodule

// File: rtl/irq_chain_arbiter.sv
module irq_chain_arbiter
   import irq_chain_pkg::*;
#(
   parameter int NUM_SRC           = 16,
   parameter int LVL_W             = 3,
   parameter int BLANK_CYC         = 2,
   parameter bit HALF_CYCLE_SAMPLE = 1'b1,
   localparam int IDX_W            = $clog2(NUM_SRC)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fetch_i,
   input  logic [NUM_SRC-1:0]       req_i,
   input  logic [NUM_SRC*LVL_W-1:0] lvl_i,
   input  logic [LVL_W-1:0]         ipl_i,
   input  logic                     iflag_i,
   input  logic                     nmi_reset_i,
   input  logic                     nmi_debug_i,
   input  logic                     nmi_wdog_i,
   output logic                     accept_o,
   output logic [1:0]               kind_o,
   output logic [IDX_W-1:0]         vec_o,
   output logic [LVL_W-1:0]         new_ipl_o,
   output logic [NUM_SRC-1:0]       clr_o,
   output logic                     set_iflag_o
);
   localparam int CNT_W = $clog2(BLANK_CYC + 2);

   generate
      if (NUM_SRC < 2 || NUM_SRC > 64) begin : g_bad_src
         $error("NUM_SRC must lie in 2..64");
      end
      if (LVL_W < 1 || LVL_W > 8) begin : g_bad_lvl
         $error("LVL_W must lie in 1..8");
      end
      if (BLANK_CYC < 1 || BLANK_CYC > 15) begin : g_bad_blank
         $error("BLANK_CYC must lie in 1..15");
      end
   endgenerate

   // detection pacing
   logic [CNT_W-1:0] cnt_q;
   logic             busy, take, fire;

   assign busy = (cnt_q != '0);
   assign take = fetch_i && !busy;
   assign fire = (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (take) cnt_q <= CNT_W'(BLANK_CYC);
      else if (busy) cnt_q <= cnt_q - CNT_W'(1);
   end

   // input snapshot
   logic [NUM_SRC-1:0]       snap_req;
   logic [NUM_SRC*LVL_W-1:0] snap_lvl;
   logic [LVL_W-1:0]         snap_ipl;
   logic                     snap_iflag;
   logic [2:0]               snap_nmi;

   irq_snapshot #(
      .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .HALF_CYCLE_SAMPLE(HALF_CYCLE_SAMPLE)
   ) u_snap (
      .clk(clk), .rst_n(rst_n), .take_i(take), .hold_i(busy),
      .req_i(req_i), .lvl_i(lvl_i), .ipl_i(ipl_i), .iflag_i(iflag_i),
      .nmi_i({nmi_reset_i, nmi_debug_i, nmi_wdog_i}),
      .snap_req_o(snap_req), .snap_lvl_o(snap_lvl), .snap_ipl_o(snap_ipl),
      .snap_iflag_o(snap_iflag), .snap_nmi_o(snap_nmi)
   );

   // serial compare chain, position 0 at the top
   logic             ch_vld [NUM_SRC+1];
   logic [LVL_W-1:0] ch_lvl [NUM_SRC+1];
   logic [IDX_W-1:0] ch_idx [NUM_SRC+1];

   assign ch_vld[0] = 1'b0;
   assign ch_lvl[0] = '0;
   assign ch_idx[0] = '0;

   generate
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_stage
         irq_chain_stage #(.LVL_W(LVL_W), .IDX_W(IDX_W), .POS(s)) u_stage (
            .up_vld_i(ch_vld[s]), .up_lvl_i(ch_lvl[s]), .up_idx_i(ch_idx[s]),
            .own_req_i(snap_req[s]), .own_lvl_i(snap_lvl[s*LVL_W +: LVL_W]),
            .dn_vld_o(ch_vld[s+1]), .dn_lvl_o(ch_lvl[s+1]), .dn_idx_o(ch_idx[s+1])
         );
      end
   endgenerate

   // acceptance against level and disable flag
   logic               g_acc, g_seti;
   src_kind_e          g_kind;
   logic [IDX_W-1:0]   g_vec;
   logic [LVL_W-1:0]   g_ipl;
   logic [NUM_SRC-1:0] g_clr;

   irq_accept_gate #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_gate (
      .win_vld_i(ch_vld[NUM_SRC]), .win_lvl_i(ch_lvl[NUM_SRC]),
      .win_idx_i(ch_idx[NUM_SRC]), .ipl_i(snap_ipl), .iflag_i(snap_iflag),
      .nmi_i(snap_nmi), .acc_o(g_acc), .kind_o(g_kind), .vec_o(g_vec),
      .new_ipl_o(g_ipl), .clr_o(g_clr), .seti_o(g_seti)
   );

   // single-cycle result strobes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         accept_o    <= 1'b0;
         kind_o      <= 2'd0;
         vec_o       <= '0;
         new_ipl_o   <= '0;
         clr_o       <= '0;
         set_iflag_o <= 1'b0;
      end else if (fire) begin
         accept_o    <= g_acc;
         kind_o      <= g_kind;
         vec_o       <= g_vec;
         new_ipl_o   <= g_ipl;
         clr_o       <= g_clr;
         set_iflag_o <= g_seti;
      end else begin
         accept_o    <= 1'b0;
         kind_o      <= 2'd0;
         vec_o       <= '0;
         new_ipl_o   <= '0;
         clr_o       <= '0;
         set_iflag_o <= 1'b0;
      end
   end

   assert_win_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ch_vld[NUM_SRC] |-> (ch_lvl[NUM_SRC] != '0));
   assert_above_ipl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_o && kind_o == SRC_MASKABLE) |-> (new_ipl_o > snap_ipl && !snap_iflag));
   assert_clr_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_o));
   assert_clr_maskable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_o) |-> (accept_o && kind_o == SRC_MASKABLE && set_iflag_o));
   assert_fixed_noclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_o && kind_o != SRC_MASKABLE) |-> (clr_o == '0 && vec_o == '0));
   assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |=> !accept_o);
   assert_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !take);
endmodule

// File: tb/irq_chain_arbiter_tb.sv
module irq_chain_arbiter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_i = 1'b0;
   logic [15:0] req_i = '0;
   logic [47:0] lvl_i = '0;
   logic [2:0]  ipl_i = '0;
   logic        iflag_i = 1'b0;
   logic        nmi_reset_i = 1'b0, nmi_debug_i = 1'b0, nmi_wdog_i = 1'b0;
   logic        accept_o, set_iflag_o;
   logic [1:0]  kind_o;
   logic [3:0]  vec_o;
   logic [2:0]  new_ipl_o;
   logic [15:0] clr_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   irq_chain_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .fetch_i(fetch_i), .req_i(req_i), .lvl_i(lvl_i),
      .ipl_i(ipl_i), .iflag_i(iflag_i), .nmi_reset_i(nmi_reset_i),
      .nmi_debug_i(nmi_debug_i), .nmi_wdog_i(nmi_wdog_i), .accept_o(accept_o),
      .kind_o(kind_o), .vec_o(vec_o), .new_ipl_o(new_ipl_o), .clr_o(clr_o),
      .set_iflag_o(set_iflag_o)
   );

   typedef struct packed {
      logic [7:0]  rq;
      logic [15:0] req;
      logic [2:0]  base;
      logic [3:0]  ia;
      logic [2:0]  la;
      logic [3:0]  ib;
      logic [2:0]  lb;
      logic [2:0]  ipl;
      logic        ifl;
      logic [2:0]  nmi;   // {reset, debug, watchdog}
      logic        acc;
      logic [1:0]  kind;
      logic [3:0]  vec;
      logic [2:0]  nipl;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t TBL [NV] = '{
      '{8'd1, 16'h0020, 3'd0, 4'd5,  3'd4, 4'd5,  3'd4, 3'd2, 1'b0, 3'b000, 1'b1, 2'd0, 4'd5,  3'd4}, // R1
      '{8'd1, 16'h0208, 3'd0, 4'd3,  3'd2, 4'd9,  3'd6, 3'd1, 1'b0, 3'b000, 1'b1, 2'd0, 4'd9,  3'd6}, // R1
      '{8'd2, 16'h0208, 3'd0, 4'd3,  3'd5, 4'd9,  3'd5, 3'd0, 1'b0, 3'b000, 1'b1, 2'd0, 4'd3,  3'd5}, // R2
      '{8'd1, 16'hFFFF, 3'd3, 4'd15, 3'd7, 4'd15, 3'd7, 3'd0, 1'b0, 3'b000, 1'b1, 2'd0, 4'd15, 3'd7}, // R1
      '{8'd2, 16'hFFFF, 3'd3, 4'd0,  3'd3, 4'd0,  3'd3, 3'd0, 1'b0, 3'b000, 1'b1, 2'd0, 4'd0,  3'd3}, // R2
      '{8'd2, 16'h8001, 3'd0, 4'd0,  3'd6, 4'd15, 3'd6, 3'd2, 1'b0, 3'b000, 1'b1, 2'd0, 4'd0,  3'd6}, // R2
      '{8'd3, 16'h0084, 3'd0, 4'd2,  3'd0, 4'd7,  3'd1, 3'd0, 1'b0, 3'b000, 1'b1, 2'd0, 4'd7,  3'd1}, // R3
      '{8'd3, 16'h0004, 3'd0, 4'd2,  3'd0, 4'd2,  3'd0, 3'd0, 1'b0, 3'b000, 1'b0, 2'd0, 4'd0,  3'd0}, // R3
      '{8'd4, 16'h0010, 3'd0, 4'd4,  3'd3, 4'd4,  3'd3, 3'd3, 1'b0, 3'b000, 1'b0, 2'd0, 4'd0,  3'd0}, // R4
      '{8'd4, 16'h0010, 3'd0, 4'd4,  3'd4, 4'd4,  3'd4, 3'd3, 1'b0, 3'b000, 1'b1, 2'd0, 4'd4,  3'd4}, // R4
      '{8'd4, 16'h0010, 3'd0, 4'd4,  3'd7, 4'd4,  3'd7, 3'd0, 1'b1, 3'b000, 1'b0, 2'd0, 4'd0,  3'd0}, // R4
      '{8'd6, 16'h0010, 3'd0, 4'd4,  3'd7, 4'd4,  3'd7, 3'd2, 1'b1, 3'b111, 1'b1, 2'd1, 4'd0,  3'd7}, // R6
      '{8'd6, 16'h0000, 3'd0, 4'd0,  3'd0, 4'd0,  3'd0, 3'd5, 1'b0, 3'b011, 1'b1, 2'd2, 4'd0,  3'd5}, // R6
      '{8'd6, 16'h0000, 3'd0, 4'd0,  3'd0, 4'd0,  3'd0, 3'd7, 1'b1, 3'b001, 1'b1, 2'd3, 4'd0,  3'd7}, // R6
      '{8'd6, 16'h0010, 3'd0, 4'd4,  3'd7, 4'd4,  3'd7, 3'd0, 1'b0, 3'b001, 1'b1, 2'd3, 4'd0,  3'd7}  // R6
   };

   task automatic check(input string rq, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic apply(input vec_t e);
      req_i = e.req;
      for (int i = 0; i < 16; i++) lvl_i[i*3 +: 3] = e.base;
      lvl_i[e.ia*3 +: 3] = e.la;
      lvl_i[e.ib*3 +: 3] = e.lb;
      ipl_i = e.ipl;
      iflag_i = e.ifl;
      {nmi_reset_i, nmi_debug_i, nmi_wdog_i} = e.nmi;
   endtask

   // expects to be called 1 ns after a rising edge
   task automatic check_result(input string rq, input logic acc, input logic [1:0] kind,
                               input logic [3:0] vec, input logic [2:0] nipl);
      logic [15:0] exp_clr;
      exp_clr = (acc && kind == 2'd0) ? (16'h1 << vec) : 16'h0;
      check(rq, "accept", 32'(accept_o), 32'(acc));
      check(rq, "kind", 32'(kind_o), 32'(kind));
      check(rq, "vec", 32'(vec_o), 32'(vec));
      check(rq, "new_ipl", 32'(new_ipl_o), 32'(nipl));
      check(rq, "clr", 32'(clr_o), 32'(exp_clr));
      check(rq, "set_iflag", 32'(set_iflag_o), 32'(acc));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R7 watchdog: actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      // R11: outputs quiet while reset is held, even with requests present
      req_i = 16'hFFFF; lvl_i = '1; nmi_reset_i = 1'b1; fetch_i = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check("R11", "reset outputs", {accept_o, kind_o, vec_o, new_ipl_o, clr_o, set_iflag_o}, 0);
      fetch_i = 1'b0; nmi_reset_i = 1'b0; req_i = '0; lvl_i = '0;
      rst_n = 1'b1;
      @(posedge clk); #1;

      // table walk: R1..R7
      for (int k = 0; k < NV; k++) begin
         string rq;
         rq = $sformatf("R%0d", TBL[k].rq);
         apply(TBL[k]);
         fetch_i = 1'b1;
         @(posedge clk); #1;          // latch edge
         fetch_i = 1'b0;
         @(posedge clk); #1;
         check("R7", "early accept", 32'(accept_o), 0);
         @(posedge clk); #1;
         check_result(rq, TBL[k].acc, TBL[k].kind, TBL[k].vec, TBL[k].nipl);
         @(posedge clk); #1;
         check("R7", "late accept", 32'(accept_o), 0);
      end

      // R9: change after the sampling falling edge is ignored
      req_i = 16'h0040; lvl_i = '0; lvl_i[6*3 +: 3] = 3'd5; ipl_i = 3'd0; iflag_i = 1'b0;
      {nmi_reset_i, nmi_debug_i, nmi_wdog_i} = 3'b000;
      fetch_i = 1'b1;
      #2;                              // past the falling edge
      req_i = 16'h0100; lvl_i[8*3 +: 3] = 3'd7; nmi_wdog_i = 1'b1;
      @(posedge clk); #1;
      fetch_i = 1'b0;
      @(posedge clk); @(posedge clk); #1;
      check_result("R9", 1'b1, 2'd0, 4'd6, 3'd5);
      @(posedge clk); #1;

      // R10: changes during blanking are ignored
      req_i = 16'h0002; lvl_i = '0; lvl_i[1*3 +: 3] = 3'd2; ipl_i = 3'd1; nmi_wdog_i = 1'b0;
      fetch_i = 1'b1;
      @(posedge clk); #1;
      fetch_i = 1'b0;
      req_i = 16'h0800; lvl_i[11*3 +: 3] = 3'd7; iflag_i = 1'b1; nmi_reset_i = 1'b1;
      @(posedge clk); #1;
      ipl_i = 3'd7;
      @(posedge clk); #1;
      check_result("R10", 1'b1, 2'd0, 4'd1, 3'd2);
      @(posedge clk); #1;

      // R8: fetch held high -> detections every three cycles
      req_i = 16'h0001; lvl_i = '0; lvl_i[2:0] = 3'd3; ipl_i = 3'd0; iflag_i = 1'b0;
      nmi_reset_i = 1'b0;
      fetch_i = 1'b1;
      @(posedge clk); #1;              // first latch
      for (int c = 1; c <= 9; c++) begin
         @(posedge clk); #1;
         check("R8", $sformatf("pulse at edge %0d", c), 32'(accept_o), 32'(c % 3 == 2));
      end
      fetch_i = 1'b0;
      repeat (4) @(posedge clk);
      #1;
      check("R7", "idle after burst", 32'(accept_o), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule